// File: doc/BRIEF.md
# Supply Monitor Interrupt Status Unit

This block turns three asynchronous condition signals from a secondary I/O supply domain into level-sensitive interrupt flags. The three conditions are: the domain is held in power-on reset, the supply has not reached its operating level, and the supply has dropped below a selectable low-voltage threshold. Each condition passes through a two-flop synchronizer. The synchronized value then drives a flag that software can read but cannot clear. The flag drops only when its condition goes away.

Each flag produces two registered outputs. The interrupt request is gated by a per-source enable bit. The DMA trigger ignores the enables. A small register interface does three things: it sets the interrupt enables, it sets the low-voltage-detect enable and the threshold selection that go to the comparator, and it reads back the flags and a status word. The status word holds a combined "supply not usable" bit and a low-voltage status bit. Because the flags are levels, software is expected to do the following when a request fires: mask that source's enable, poll the status until the supply recovers, and then unmask the source.

Top module: `supmon_irq_top`

## Requirements
- R1: There are three sources, and each uses the same bit position in the flag word, in `irq_o` and in `dma_o`: bit 0 is power-on reset active, bit 1 is supply not ready, and bit 2 is low voltage detected.
- R2: `irq_o[i]` is high exactly one clock after flag i and enable bit i are both high. It is low otherwise.
- R3: Each flag is high exactly while its synchronized condition is high. A change on `cond_i` first appears in the flag word after the second rising clock edge. The flag clears by itself when the condition goes away.
- R4: A write to the flag word (address 2) changes no flag and no control register.
- R5: `dma_o[i]` is high exactly one clock after flag i is high, whatever the value of enable bit i.
- R6: Status word (address 3) bit 0 reads as the OR of flag 0 and flag 1.
- R7: When low-voltage detection is disabled, flag 2, `irq_o[2]` and `dma_o[2]` stay low even if `cond_i[2]` is high.
- R8: Status word bit 1 reads the same value as flag 2.
- R9: After reset, the following are zero: the enables, the low-voltage-detect enable, the threshold selection, `irq_o` and `dma_o`.
- R10: Address 0 holds the interrupt enables in bits 2:0. Address 1 holds the low-voltage-detect enable in bit 0 and the threshold selection in bits 4:1. These fields drive `lvd_en_o` and `lvd_thr_o`, and they read back unchanged. Writes take effect on the clock edge that samples `wr_en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | 3 | Asynchronous supply conditions: bit 0 POR, bit 1 not ready, bit 2 below threshold |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| lvd_en_o | output | 1 | Low-voltage-detect enable to the comparator |
| lvd_thr_o | output | 4 | Threshold selection to the comparator |
| irq_o | output | 3 | Registered interrupt requests |
| dma_o | output | 3 | Registered DMA triggers |

## Verification
Four rules are checked on every cycle:
- No request is raised without its enable set on the previous cycle.
- A request always comes with its DMA trigger.
- A disabled low-voltage detector never produces a low-voltage trigger.
- A write to the flag word leaves the control registers untouched.

Some behaviours can only be shown by the bench's scenarios. These are the exact two-edge flag latency and the extra edge on the outputs, the self-clearing of flags as conditions fall, the status word contents, and the fact that a write to the flag word cannot clear a flag whose condition persists.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_POR  = 0;
  localparam int SRC_NRDY = 1;
  localparam int SRC_LVD  = 2;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam int THR_W    = 4;
  localparam int SYNC_N   = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_IEN  = 2'd0,
    REG_LVDC = 2'd1,
    REG_FLAG = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   flags_i,
  output logic [NSRC-1:0]   irq_en_o,
  output logic              lvd_en_o,
  output logic [THR_W-1:0]  lvd_thr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LVDC_W = THR_W + 1;

  logic sel_ien, sel_lvdc;
  assign sel_ien  = wr_en_i && (addr_i == REG_IEN);
  assign sel_lvdc = wr_en_i && (addr_i == REG_LVDC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o  <= '0;
      lvd_en_o  <= 1'b0;
      lvd_thr_o <= '0;
    end else begin
      if (sel_ien)  irq_en_o <= wdata_i[NSRC-1:0];
      if (sel_lvdc) begin
        lvd_en_o  <= wdata_i[0];
        lvd_thr_o <= wdata_i[LVDC_W-1:1];
      end
    end
  end

  // flag word is read-only: no write path exists for REG_FLAG
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_IEN:  rdata_o[NSRC-1:0]   = irq_en_o;
      REG_LVDC: rdata_o[LVDC_W-1:0] = {lvd_thr_o, lvd_en_o};
      REG_FLAG: rdata_o[NSRC-1:0]   = flags_i;
      REG_STAT: rdata_o[1:0]        = {flags_i[SRC_LVD], flags_i[SRC_POR] | flags_i[SRC_NRDY]};
      default:  rdata_o = '0;
    endcase
  end

  // R4
  flag_wr_noeffect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_FLAG) |=> ($stable(irq_en_o) && $stable(lvd_en_o) && $stable(lvd_thr_o)));
endmodule

// File: rtl/supmon_flags.sv
module supmon_flags
  import supmon_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] cond_sync_i,
  input  logic            lvd_en_i,
  input  logic [NSRC-1:0] irq_en_i,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] irq_o,
  output logic [NSRC-1:0] dma_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    if (i == SRC_LVD) begin : g_gated
      assign flags_o[i] = cond_sync_i[i] & lvd_en_i;
    end else begin : g_plain
      assign flags_o[i] = cond_sync_i[i];
    end
  end

  // registered so enable writes cannot glitch the outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= '0;
      dma_o <= '0;
    end else begin
      irq_o <= flags_o & irq_en_i;
      dma_o <= flags_o;
    end
  end

  // R2
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(irq_en_i)) == '0);
  // R5
  irq_implies_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~dma_o) == '0);
  // R7
  lvd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lvd_en_i) |-> !dma_o[SRC_LVD]);
endmodule

// File: rtl/supmon_irq_top.sv
module supmon_irq_top
  import supmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   cond_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lvd_en_o,
  output logic [THR_W-1:0]  lvd_thr_o,
  output logic [NSRC-1:0]   irq_o,
  output logic [NSRC-1:0]   dma_o
);
  logic [NSRC-1:0] cond_sync, flags, irq_en;

  supmon_sync #(.WIDTH(NSRC), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cond_i),
    .q_o    (cond_sync)
  );

  supmon_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cond_sync_i (cond_sync),
    .lvd_en_i    (lvd_en_o),
    .irq_en_i    (irq_en),
    .flags_o     (flags),
    .irq_o       (irq_o),
    .dma_o       (dma_o)
  );

  supmon_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flags_i   (flags),
    .irq_en_o  (irq_en),
    .lvd_en_o  (lvd_en_o),
    .lvd_thr_o (lvd_thr_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: tb/supmon_irq_top_tb.sv
module supmon_irq_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cond_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       lvd_en_o;
  logic [3:0] lvd_thr_o;
  logic [2:0] irq_o, dma_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  supmon_irq_top u_dut (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    // R9
    chk("R9 irq", {5'd0, irq_o}, 8'h0);
    chk("R9 dma", {5'd0, dma_o}, 8'h0);
    chk("R9 lvd_en", {7'd0, lvd_en_o}, 8'h0);
    chk("R9 thr", {4'd0, lvd_thr_o}, 8'h0);
    rd(2'd0, d); chk("R9 ien", d, 8'h0);
    rd(2'd1, d); chk("R9 lvdc", d, 8'h0);
  endtask

  task automatic t_por_latency;
    logic [7:0] d;
    cond_i = 3'b001;
    cyc(1); rd(2'd2, d); chk("R3 flag after 1 edge", d, 8'h0);
    cyc(1); rd(2'd2, d); chk("R3 flag after 2 edges R1", d, 8'h01);
    chk("R5 dma not yet", {5'd0, dma_o}, 8'h0);
    cyc(1);
    chk("R5 dma without enable", {5'd0, dma_o}, 8'h01);
    chk("R2 irq masked", {5'd0, irq_o}, 8'h0);
    rd(2'd3, d); chk("R6 status por", d, 8'h01);
    wr(2'd0, 8'h01); cyc(1);
    chk("R2 irq enabled", {5'd0, irq_o}, 8'h01);
    wr(2'd0, 8'h00); cyc(1);
    chk("R2 irq masked again", {5'd0, irq_o}, 8'h0);
    chk("R5 dma kept", {5'd0, dma_o}, 8'h01);
    cond_i = 3'b000; cyc(2);
    rd(2'd2, d); chk("R3 flag self-clear", d, 8'h0);
    cyc(1); chk("R5 dma clear", {5'd0, dma_o}, 8'h0);
  endtask

  task automatic t_flag_ro;
    logic [7:0] d;
    cond_i = 3'b010; cyc(3);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R4 flag survives write", d, 8'h02);
    rd(2'd0, d); chk("R4 ien untouched", d, 8'h0);
    rd(2'd1, d); chk("R4 lvdc untouched", d, 8'h0);
    rd(2'd3, d); chk("R6 status nrdy", d, 8'h01);
    wr(2'd0, 8'h02); cyc(1);
    chk("R2 nrdy irq", {5'd0, irq_o}, 8'h02);
    cond_i = 3'b000; cyc(3);
    chk("R2 irq drops with flag", {5'd0, irq_o}, 8'h0);
    rd(2'd3, d); chk("R6 status clear", d, 8'h0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_lvd;
    logic [7:0] d;
    cond_i = 3'b100; cyc(3);
    wr(2'd0, 8'h04); cyc(1);
    rd(2'd2, d); chk("R7 flag gated", d, 8'h0);
    chk("R7 dma gated", {5'd0, dma_o}, 8'h0);
    chk("R7 irq gated", {5'd0, irq_o}, 8'h0);
    wr(2'd1, 8'h15);
    chk("R10 lvd_en", {7'd0, lvd_en_o}, 8'h01);
    chk("R10 thr", {4'd0, lvd_thr_o}, 8'h0a);
    rd(2'd1, d); chk("R10 lvdc readback", d, 8'h15);
    rd(2'd2, d); chk("R7 flag enabled", d, 8'h04);
    rd(2'd3, d); chk("R8 status lvd", d, 8'h02);
    cyc(1);
    chk("R2 lvd irq", {5'd0, irq_o}, 8'h04);
    chk("R5 lvd dma", {5'd0, dma_o}, 8'h04);
    wr(2'd1, 8'h14);
    rd(2'd2, d); chk("R7 flag off again", d, 8'h0);
    cyc(1); chk("R7 dma off again", {5'd0, dma_o}, 8'h0);
    wr(2'd1, 8'h01);
    cond_i = 3'b000; cyc(2);
    rd(2'd3, d); chk("R8 status recovers", d, 8'h0);
  endtask

  task automatic t_mixed;
    logic [7:0] d;
    wr(2'd0, 8'h05);
    cond_i = 3'b111; cyc(3);
    rd(2'd0, d); chk("R10 ien readback", d, 8'h05);
    rd(2'd2, d); chk("R1 all flags", d, 8'h07);
    rd(2'd3, d); chk("R6 R8 status both", d, 8'h03);
    chk("R2 selective irq", {5'd0, irq_o}, 8'h05);
    chk("R5 all dma", {5'd0, dma_o}, 8'h07);
    cond_i = 3'b010; cyc(3);
    chk("R2 only masked left", {5'd0, irq_o}, 8'h0);
    chk("R5 dma nrdy", {5'd0, dma_o}, 8'h02);
    cond_i = 3'b000; cyc(3);
  endtask

  initial begin
    cyc(2); t_reset();
    rst_ni = 1'b1; cyc(2);
    t_por_latency();
    t_flag_ro();
    t_lvd();
    t_mixed();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule